// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block lets a synchronous host reach an asynchronous 8K x 8 static RAM one word at a time. The host raises a request with an address, a write flag and write data while the controller shows ready. The controller then produces the memory strobes: two chip selects of opposite polarity, an active-low write strobe and an active-low output-enable strobe. For a read it returns the captured byte with a one-cycle valid pulse.

Every minimum time the memory needs is a nanosecond parameter. Each is turned into a whole number of clock cycles, rounded up and never less than one. Writes are timed by the write strobe. The output enable stays high for the whole write, and the controller drives the shared data lines only while the write strobe is low, so the two sides never drive the bus at the same time. After every access the controller spends one cycle with the memory deselected before it accepts the next request.

The default is a 20 ns clock. With that clock a read holds the select and output enable for 4 cycles. A write holds the select for 1 setup cycle and then 3 cycles with the write strobe low.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, host_ready is 1, host_rvalid is 0, mem_ce1_n is 1, mem_ce2 is 0, mem_we_n is 1, mem_oe_n is 1 and mem_dq_oe is 0.
- R2: A request is taken only on a clock edge where host_req and host_ready are both 1. host_ready is 1 only when the controller is idle. A request raised while host_ready is 0 starts no memory access and changes no memory word.
- R3: The memory counts as selected when mem_ce1_n is 0 and mem_ce2 is 1. The two selects always switch together: mem_ce1_n equals the inverse of mem_ce2 in every cycle.
- R4: A read keeps the memory selected with mem_oe_n low for RD_CYC cycles. RD_CYC is the largest of ceil(70/T), ceil(70/T) and ceil(40/T), where T is the clock period. This gives at least 70 ns of select and at least 40 ns of output enable.
- R5: Read data is sampled from mem_dq_in on the last clock edge of the read window, while mem_oe_n is still low. host_rvalid is 1 for exactly one cycle, the cycle right after the RD_CYC-th cycle of the access, and host_rdata holds the byte stored at the address.
- R6: A write first keeps the memory selected with mem_we_n high for WS_CYC cycles, then with mem_we_n low for WP_CYC cycles. WP_CYC is max(ceil(50/T), ceil(35/T)). WS_CYC is the smallest count of at least 1 that makes WS_CYC+WP_CYC at least both ceil(70/T) and ceil(65/T). This gives a write strobe of at least 50 ns, select of at least 65 ns before the strobe ends, and a cycle of at least 70 ns.
- R7: mem_oe_n stays 1 in every cycle of a write access.
- R8: mem_dq_oe is 1 exactly in the cycles where mem_we_n is 0. During those cycles mem_dq_out holds the request's write data and does not change, so data is set up for at least 35 ns before the write strobe rises. mem_dq_oe is 0 during reads.
- R9: After every access there is one cycle with the memory deselected and host_ready 0. For a read this cycle carries the host_rvalid pulse. host_ready returns the cycle after it.
- R10: While the memory is selected, mem_addr equals the address of the accepted request and stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host request, taken when host_ready is 1 |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 13 | Word address |
| host_wdata | input | 8 | Write data |
| host_ready | output | 1 | Controller idle and able to take a request |
| host_rdata | output | 8 | Last byte read |
| host_rvalid | output | 1 | One-cycle pulse when host_rdata is new |
| mem_addr | output | 13 | Memory address lines |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Value driven onto the data lines |
| mem_dq_oe | output | 1 | Enables the controller's data driver |
| mem_dq_in | input | 8 | Value seen on the data lines |

## Verification
A request is taken on the edge where host_req and host_ready are both 1. Counting from that edge, a read keeps host_ready low for RD_CYC+1 cycles, and host_rvalid appears in the last of them (the fifth with defaults). A write keeps host_ready low for WS_CYC+WP_CYC+1 cycles (also five). The bench drives inputs and samples every output on the falling clock edge. It counts those samples from the accept edge and checks each result at the exact count the bench computes from the nanosecond limits. Pulse lengths are measured in time between strobe edges, and bus ownership is checked on every falling edge.

// File: rtl/sramc_pkg.sv
`timescale 1ns/1ps
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_WSETUP = 3'd2,
        ST_WPULSE = 3'd3,
        ST_GAP    = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic sel;   // memory selected (both chip selects active)
        logic we_n;  // write strobe level
        logic oe_n;  // output enable level
        logic drv;   // controller drives data lines
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{sel: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

    // Whole clock cycles covering a nanosecond minimum, never less than one.
    function automatic int cycles_for(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Strobe levels that belong to a state.
    function automatic strobe_t strobe_of(input seq_state_e st);
        strobe_t s;
        s = STROBE_IDLE;
        case (st)
            ST_READ:   begin s.sel = 1'b1; s.oe_n = 1'b0; end
            ST_WSETUP: begin s.sel = 1'b1; end
            ST_WPULSE: begin s.sel = 1'b1; s.we_n = 1'b0; s.drv = 1'b1; end
            default:   s = STROBE_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sramc_phase_timer.sv
`timescale 1ns/1ps
module sramc_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R4/R6: each phase length comes from a steady one-per-cycle count
    a_r4_timer_steps: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sramc_seq.sv
`timescale 1ns/1ps
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int CNT_W  = 3,
    parameter int RD_CYC = 4,
    parameter int WS_CYC = 1,
    parameter int WP_CYC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_we,
    input  logic             expired,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output strobe_t          strb,
    output logic             capture,
    output logic             ready
);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WS_LOAD = CNT_W'(WS_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYC - 1);

    seq_state_e state_q, state_n;
    strobe_t    strb_q;

    always_comb begin
        state_n  = state_q;
        load     = 1'b0;
        load_val = '0;
        capture  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load     = 1'b1;
                    load_val = start_we ? WS_LOAD : RD_LOAD;
                    state_n  = start_we ? ST_WSETUP : ST_READ;
                end
            end
            ST_READ: begin
                if (expired) begin
                    capture = 1'b1;
                    state_n = ST_GAP;
                end
            end
            ST_WSETUP: begin
                if (expired) begin
                    load     = 1'b1;
                    load_val = WP_LOAD;
                    state_n  = ST_WPULSE;
                end
            end
            ST_WPULSE: begin
                if (expired) state_n = ST_GAP;
            end
            ST_GAP:  state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // Strobes are registered from the next state so the pins never glitch.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            strb_q  <= STROBE_IDLE;
        end else begin
            state_q <= state_n;
            strb_q  <= strobe_of(state_n);
        end
    end

    assign strb  = strb_q;
    assign ready = (state_q == ST_IDLE);

    // R7: output enable held high whenever the write strobe is low
    a_r7_g_high_in_pulse: assert property (@(posedge clk) disable iff (rst)
        !strb.we_n |-> strb.oe_n);

    // R6: write strobe falls only after a cycle of select
    a_r6_select_before_w: assert property (@(posedge clk) disable iff (rst)
        $fell(strb.we_n) |-> $past(strb.sel));

    // R9: leaving select is followed by a non-ready cycle
    a_r9_gap_after_access: assert property (@(posedge clk) disable iff (rst)
        $fell(strb.sel) |-> !ready);

    // R2: no new access starts straight out of another
    a_r2_start_from_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(strb.sel) |-> $past(ready));

endmodule

// File: rtl/async_sram_ctrl.sv
`timescale 1ns/1ps
module async_sram_ctrl
    import sramc_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_RCYC_NS     = 70,
    parameter int T_ACC_NS      = 70,
    parameter int T_OEACC_NS    = 40,
    parameter int T_WCYC_NS     = 70,
    parameter int T_WPULSE_NS   = 50,
    parameter int T_SELW_NS     = 65,
    parameter int T_DSETUP_NS   = 35
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int RD_CYC  = imax(imax(cycles_for(T_RCYC_NS, CLK_PERIOD_NS),
                                       cycles_for(T_ACC_NS, CLK_PERIOD_NS)),
                                  cycles_for(T_OEACC_NS, CLK_PERIOD_NS));
    localparam int WP_CYC  = imax(cycles_for(T_WPULSE_NS, CLK_PERIOD_NS),
                                  cycles_for(T_DSETUP_NS, CLK_PERIOD_NS));
    localparam int WS_CYC  = imax(1, imax(cycles_for(T_WCYC_NS, CLK_PERIOD_NS) - WP_CYC,
                                          cycles_for(T_SELW_NS, CLK_PERIOD_NS) - WP_CYC));
    localparam int MAX_CYC = imax(RD_CYC, imax(WS_CYC, WP_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             accept;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;
    logic             capture;
    strobe_t          strb;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    assign accept = host_req && host_ready;

    sramc_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sramc_seq #(
        .CNT_W  (CNT_W),
        .RD_CYC (RD_CYC),
        .WS_CYC (WS_CYC),
        .WP_CYC (WP_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (host_req),
        .start_we (host_we),
        .expired  (expired),
        .load     (load),
        .load_val (load_val),
        .strb     (strb),
        .capture  (capture),
        .ready    (host_ready)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= host_addr;
                wdata_q <= host_wdata;
            end
            if (capture) rdata_q <= mem_dq_in;
            rvalid_q <= capture;
        end
    end

    assign mem_addr    = addr_q;
    assign mem_ce1_n   = ~strb.sel;
    assign mem_ce2     = strb.sel;
    assign mem_we_n    = strb.we_n;
    assign mem_oe_n    = strb.oe_n;
    assign mem_dq_out  = wdata_q;
    assign mem_dq_oe   = strb.drv;
    assign host_rdata  = rdata_q;
    assign host_rvalid = rvalid_q;

    // R5: read valid is a single-cycle pulse
    a_r5_rvalid_single: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |=> !host_rvalid);

    // R10: address steady while selected
    a_r10_addr_steady: assert property (@(posedge clk) disable iff (rst)
        (mem_ce2 && $past(mem_ce2)) |-> $stable(mem_addr));

    // R8: driven data steady across the write strobe
    a_r8_data_steady: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));

    // R8: driver never on while output enable is low
    a_r8_no_contention: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

endmodule

// File: tb/async_sram_ctrl_bench.sv
`timescale 1ns/1ps
module async_sram_ctrl_bench;
    localparam int CLK_NS = 20;
    localparam int AW = 13;
    localparam int DW = 8;

    function automatic int cdiv(input int a, input int b);
        int c;
        c = (a + b - 1) / b;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RD = mx(cdiv(70, CLK_NS), cdiv(40, CLK_NS));
    localparam int E_WP = mx(cdiv(50, CLK_NS), cdiv(35, CLK_NS));
    localparam int E_WS = mx(1, mx(cdiv(70, CLK_NS), cdiv(65, CLK_NS)) - E_WP);
    localparam int E_RD_BUSY = E_RD + 1;
    localparam int E_WR_BUSY = E_WS + E_WP + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_req = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_ready;
    logic [DW-1:0] host_rdata;
    logic          host_rvalid;
    logic [AW-1:0] mem_addr;
    logic          mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    bit started = 1'b0;
    bit cur_we = 1'b0;

    logic [DW-1:0] model_mem [0:255];
    logic [DW-1:0] exp_mem   [0:255];

    int err_r3 = 0, err_r7 = 0, err_r8 = 0;
    int ops_seen = 0, ops_issued = 0;
    realtime t_sel_on = 0, t_sel_off = 0, t_w_fall = 0, t_g_fall = 0;
    real rd_sel_min = 1.0e9, wr_sel_min = 1.0e9, w_min = 1.0e9;
    real cw_min = 1.0e9, g_min = 1.0e9, gap_min = 1.0e9;

    always #(CLK_NS/2) clk = ~clk;

    async_sram_ctrl #(.CLK_PERIOD_NS(CLK_NS)) u_async_sram_ctrl (
        .clk (clk), .rst (rst),
        .host_req (host_req), .host_we (host_we), .host_addr (host_addr),
        .host_wdata (host_wdata), .host_ready (host_ready),
        .host_rdata (host_rdata), .host_rvalid (host_rvalid),
        .mem_addr (mem_addr), .mem_ce1_n (mem_ce1_n), .mem_ce2 (mem_ce2),
        .mem_we_n (mem_we_n), .mem_oe_n (mem_oe_n),
        .mem_dq_out (mem_dq_out), .mem_dq_oe (mem_dq_oe), .mem_dq_in (mem_dq_in)
    );

    wire sel = !mem_ce1_n && mem_ce2;

    // Memory model: drives the stored byte only while read-enabled, else its complement.
    assign mem_dq_in = (sel && !mem_oe_n && mem_we_n) ? model_mem[mem_addr[7:0]]
                                                      : ~model_mem[mem_addr[7:0]];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Per-cycle bus ownership monitor
    always @(negedge clk) begin
        if (started) begin
            if (mem_ce1_n == mem_ce2) err_r3++;
            if (sel && !mem_we_n) begin
                if (!mem_dq_oe) err_r8++;
                model_mem[mem_addr[7:0]] <= mem_dq_out;
            end
            if (mem_dq_oe && mem_we_n) err_r8++;
            if (mem_dq_oe && !mem_oe_n) err_r8++;
            if (sel && cur_we && !mem_oe_n) err_r7++;
            if (!mem_we_n && !mem_oe_n) err_r7++;
        end
    end

    // Pulse-length monitors
    always @(posedge sel) if (started) begin
        ops_seen++;
        if (ops_seen > 1 && ($realtime - t_sel_off) < gap_min) gap_min = $realtime - t_sel_off;
        t_sel_on = $realtime;
    end
    always @(negedge sel) if (started) begin
        if (t_w_fall > t_sel_on) begin
            if (($realtime - t_sel_on) < wr_sel_min) wr_sel_min = $realtime - t_sel_on;
        end else begin
            if (($realtime - t_sel_on) < rd_sel_min) rd_sel_min = $realtime - t_sel_on;
        end
        t_sel_off = $realtime;
    end
    always @(negedge mem_we_n) if (started) t_w_fall = $realtime;
    always @(posedge mem_we_n) if (started) begin
        if (($realtime - t_w_fall) < w_min) w_min = $realtime - t_w_fall;
        if (($realtime - t_sel_on) < cw_min) cw_min = $realtime - t_sel_on;
    end
    always @(negedge mem_oe_n) if (started) t_g_fall = $realtime;
    always @(posedge mem_oe_n) if (started) begin
        if (($realtime - t_g_fall) < g_min) g_min = $realtime - t_g_fall;
    end

    // One host access; inject raises a write request while busy (R2).
    task automatic host_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input bit inject, input logic [AW-1:0] ia,
                           output logic [DW-1:0] rd, output int busy, output int vpos,
                           output int addr_bad, output bit gap_sel);
        int guard;
        guard = 0;
        while (!host_ready && guard < 100) begin @(negedge clk); guard++; end
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d; cur_we = we;
        ops_issued++;
        @(negedge clk);
        host_req = 1'b0;
        busy = 0; vpos = -1; addr_bad = 0; gap_sel = 1'b0; rd = '0;
        while (!host_ready && busy < 100) begin
            busy++;
            if (host_rvalid) begin vpos = busy; rd = host_rdata; end
            if (sel && mem_addr != a) addr_bad++;
            gap_sel = sel;
            if (inject && busy == 2) begin
                host_req = 1'b1; host_we = 1'b1; host_addr = ia; host_wdata = 8'h3C;
            end else if (inject && busy == 3) begin
                host_req = 1'b0;
            end
            @(negedge clk);
        end
        host_req = 1'b0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit inject,
                            input logic [AW-1:0] ia);
        logic [DW-1:0] rd;
        int busy, vpos, ab;
        bit gs;
        host_op(1'b1, a, d, inject, ia, rd, busy, vpos, ab, gs);
        exp_mem[a[7:0]] = d;
        chk(busy == E_WR_BUSY, "R6 write busy cycles", busy, E_WR_BUSY);
        chk(vpos == -1, "R5 no rvalid on write", vpos, -1);
        chk(ab == 0, "R10 write address", ab, 0);
        chk(gs == 1'b0, "R9 write gap deselected", int'(gs), 0);
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        logic [DW-1:0] rd;
        int busy, vpos, ab;
        bit gs;
        host_op(1'b0, a, 8'h00, 1'b0, '0, rd, busy, vpos, ab, gs);
        chk(busy == E_RD_BUSY, "R4 read busy cycles", busy, E_RD_BUSY);
        chk(vpos == E_RD + 1, "R5 rvalid position", vpos, E_RD + 1);
        chk(rd == exp_mem[a[7:0]], "R5 read data", int'(rd), int'(exp_mem[a[7:0]]));
        chk(ab == 0, "R10 read address", ab, 0);
        chk(gs == 1'b0, "R9 read gap deselected", int'(gs), 0);
        chk(host_rvalid == 1'b0, "R5 rvalid one cycle", int'(host_rvalid), 0);
    endtask

    function automatic logic [AW-1:0] sweep_addr(input int i);
        logic [4:0] hi;
        logic [7:0] lo;
        hi = 5'(i) ^ 5'h15;
        lo = 8'(i * 4 + 1);
        return {hi, lo};
    endfunction

    initial begin
        for (int k = 0; k < 256; k++) begin
            model_mem[k] = 8'(k) ^ 8'hC3;
            exp_mem[k]   = 8'(k) ^ 8'hC3;
        end
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(host_ready == 1'b1, "R1 ready in reset", int'(host_ready), 1);
        chk(host_rvalid == 1'b0, "R1 rvalid in reset", int'(host_rvalid), 0);
        chk(mem_ce1_n == 1'b1 && mem_ce2 == 1'b0, "R1 deselected", int'({mem_ce1_n, mem_ce2}), 2);
        chk(mem_we_n && mem_oe_n, "R1 strobes high", int'({mem_we_n, mem_oe_n}), 3);
        chk(mem_dq_oe == 1'b0, "R1 driver off", int'(mem_dq_oe), 0);
        rst = 1'b0;
        started = 1'b1;
        @(negedge clk);
        chk(host_ready && !host_rvalid && !sel, "R1 first cycle after reset",
            int'({host_ready, host_rvalid, sel}), 4);

        // Reads of untouched words
        for (int i = 0; i < 8; i++) do_read({5'(i), 8'(i * 4 + 3)});
        // Boundary addresses
        do_write(13'h0000, 8'hA7, 1'b0, '0);
        do_write(13'h1FFF, 8'h18, 1'b0, '0);
        do_read(13'h0000);
        do_read(13'h1FFF);
        // Sweep: write then read back
        for (int i = 0; i < 64; i++) do_write(sweep_addr(i), 8'(i * 37 + 11), 1'b0, '0);
        for (int i = 0; i < 64; i++) do_read(sweep_addr(i));
        // Read right after write to the same word
        for (int i = 0; i < 8; i++) begin
            do_write(sweep_addr(i), 8'(8'hF0 - i), 1'b0, '0);
            do_read(sweep_addr(i));
        end
        // R2: a request raised while busy is ignored
        do_write(13'h0102, 8'h55, 1'b1, 13'h0107);
        @(negedge clk);
        chk(!sel, "R2 no access from busy request", int'(sel), 0);
        chk(ops_seen == ops_issued, "R2 access count", ops_seen, ops_issued);
        do_read(13'h0107);
        do_read(13'h0102);

        // Timing and ownership results
        chk(rd_sel_min >= 70.0, "R4 read select ns", int'(rd_sel_min), 70);
        chk(g_min >= 40.0, "R4 output enable ns", int'(g_min), 40);
        chk(rd_sel_min == real'(E_RD * CLK_NS), "R4 read window cycles", int'(rd_sel_min), E_RD * CLK_NS);
        chk(w_min >= 50.0, "R6 write strobe ns", int'(w_min), 50);
        chk(w_min == real'(E_WP * CLK_NS), "R6 write strobe cycles", int'(w_min), E_WP * CLK_NS);
        chk(cw_min >= 65.0, "R6 select to write end ns", int'(cw_min), 65);
        chk(wr_sel_min >= 70.0, "R6 write cycle ns", int'(wr_sel_min), 70);
        chk(w_min >= 35.0, "R8 data setup ns", int'(w_min), 35);
        chk(gap_min >= real'(CLK_NS), "R9 deselect gap ns", int'(gap_min), CLK_NS);
        chk(err_r3 == 0, "R3 select pairing", err_r3, 0);
        chk(err_r7 == 0, "R7 output enable high in writes", err_r7, 0);
        chk(err_r8 == 0, "R8 driver ownership", err_r8, 0);
        chk(ops_seen == ops_issued, "R2 total accesses", ops_seen, ops_issued);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule